// File: doc/BRIEF.md
# Protected Two-Wire EEPROM Command Controller

This block is the addressing and command core of a 1024-byte serial EEPROM slave. A bus front end, outside this block, finds start and stop conditions and hands over whole bytes. This block decodes the device-select byte and keeps a block register and an offset counter. It stores written bytes into a register array and returns read bytes on request. The array is split into four 256-byte blocks, and each block is addressed by a block number and a byte offset.

The array is also split into eight protection regions of 128 bytes each, taken from address bits [9:7]. A small configuration area holds one sticky bit and one protect bit for each region, plus one more pair that guards the configuration area itself. A protect bit blocks writes to its region. A set sticky bit lets its protect bit be raised but never lowered. A power-good input holds the command logic idle while it is low, and it forces every sticky bit to 1.

Read commands never change the block register. A sequential read wraps back to the start of the current block. A long page write wraps inside its 16-byte page.

Top module: `guarded_eeprom_ctrl`

## Requirements
- R1: A select byte is addressed when bits [7:5] are 101 and bit 3 equals `hw_addr`. Bit 4 = 0 selects the array and bit 4 = 1 selects the configuration area. Bit 0 = 1 means read. While power is good, every received byte gives an `ack_valid` pulse one cycle later. `ack` is 1 only for a matching select byte and for the offset and data bytes of an addressed write.
- R2: An array write select copies select bits [2:1] into the block register. Read selects and configuration selects leave the block register unchanged.
- R3: The first byte after a write select loads the 8-bit offset. Each later data byte is stored at {block, offset}, and then the low 4 offset bits advance modulo 16 while the upper 4 bits hold. A write of more than 16 bytes therefore overwrites earlier bytes of the same page.
- R4: A `tx_req` in a read gives `tx_valid` one cycle later, with the byte at {block, offset}. The offset then advances modulo 256, so a read that passes offset 255 continues at offset 0 of the same block.
- R5: A read without a preceding offset byte starts at the offset left by the last access.
- R6: A data byte whose region has its protect bit set is not stored, and it is still acknowledged.
- R7: Configuration byte k is addressed by the low 4 offset bits. For k = 0..7, bit 7 is the sticky bit and bit 0 is the protect bit of region k. Byte 8 holds the pair for the configuration area. Bits 6..1 read 0. Bytes 9..15 read 0 and ignore writes.
- R8: A configuration write sets the sticky bit to data bit 7. It sets the protect bit to data bit 0, OR-ed with the old protect bit when the old sticky bit was 1.
- R9: While protect bit 8 is set, writes to the configuration area are discarded.
- R10: While `pwr_good` is low, no `ack_valid` or `tx_valid` is produced, the command state returns to idle and all sticky bits become 1. After power returns, bytes that arrive before a new start get `ack` = 0.
- R11: After reset, the array holds zeros, the block and offset are 0, all protect bits are 0, all sticky bits are 1 and the handshake outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply-good; low holds the command logic idle |
| hw_addr | input | 1 | Strapped device address bit matched against select bit 3 |
| bus_start | input | 1 | Start condition pulse from the front end |
| bus_stop | input | 1 | Stop condition pulse from the front end |
| rx_valid | input | 1 | Received-byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Master asks for the next read byte |
| ack_valid | output | 1 | Acknowledge decision is valid |
| ack | output | 1 | 1 = byte acknowledged |
| tx_valid | output | 1 | Read byte is valid |
| tx_byte | output | 8 | Read byte |

## Verification
A power-good drop can land in the same cycle as a data byte of a write. The bench provokes this by lowering `pwr_good` on the very cycle that carries a data strobe. It then checks that no acknowledge appears, that the byte never reaches the array, and that later bytes sent without a new start are refused. A second overlap is a write to a protected region that lands on the page-wrap point. Random page writes that cross protected regions and run past 16 bytes are compared against a reference array, so the wrap and the protection gate are judged together.

// File: rtl/guarded_eeprom_ctrl.sv
module guarded_eeprom_ctrl #(
  parameter int BLOCKS      = 4,
  parameter int BLOCK_BYTES = 256,
  parameter int PAGE_BYTES  = 16,
  parameter int REGIONS     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       hw_addr,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tx_req,
  output logic       ack_valid,
  output logic       ack,
  output logic       tx_valid,
  output logic [7:0] tx_byte
);
  localparam int BW    = $clog2(BLOCKS);
  localparam int OW    = $clog2(BLOCK_BYTES);
  localparam int AW    = BW + OW;
  localparam int PW    = $clog2(PAGE_BYTES);
  localparam int NW    = $clog2(REGIONS);
  localparam int DEPTH = BLOCKS * BLOCK_BYTES;
  localparam logic [3:0] CFG_LAST = 4'(REGIONS);

  typedef enum logic [2:0] {IDLE, SEL, OFFS, WDAT, RDAT, SKIP} st_t;

  st_t             st;
  logic [7:0]      mem [DEPTH];
  logic [BW-1:0]   blk;
  logic [OW-1:0]   off;
  logic            cfg_sel;
  logic [REGIONS:0] sticky, prot;
  logic [7:0]      cfg_rd;

  wire           live      = pwr_good && !bus_start && !bus_stop;
  wire           rx_go     = live && rx_valid;
  wire           tx_go     = live && tx_req && st == RDAT;
  wire [AW-1:0]  addr      = {blk, off};
  wire [NW-1:0]  region    = addr[AW-1 -: NW];
  wire [3:0]     cidx      = off[3:0];
  wire           sel_hit   = rx_byte[7:5] == 3'b101 && rx_byte[3] == hw_addr;
  wire           data_byte = rx_go && st == WDAT;
  wire           arr_wr    = data_byte && !cfg_sel && !prot[region];
  wire           cfg_wr    = data_byte && cfg_sel && !prot[REGIONS] && cidx <= CFG_LAST;

  always_comb cfg_rd = (cidx <= CFG_LAST) ? {sticky[cidx], 6'b0, prot[cidx]} : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; blk <= '0; off <= '0; cfg_sel <= 1'b0;
      sticky <= '1; prot <= '0;
      ack_valid <= 1'b0; ack <= 1'b0; tx_valid <= 1'b0; tx_byte <= 8'h00;
    end else if (!pwr_good) begin
      st <= IDLE; sticky <= '1;
      ack_valid <= 1'b0; ack <= 1'b0; tx_valid <= 1'b0;
    end else begin
      ack_valid <= rx_go;
      ack       <= 1'b0;
      tx_valid  <= tx_go;
      if (tx_go) begin
        tx_byte <= cfg_sel ? cfg_rd : mem[addr];
        off     <= off + 1'b1;
      end
      if (bus_start) st <= SEL;
      else if (bus_stop) st <= IDLE;
      else if (rx_go) begin
        case (st)
          SEL: if (sel_hit) begin
                 ack     <= 1'b1;
                 cfg_sel <= rx_byte[4];
                 st      <= rx_byte[0] ? RDAT : OFFS;
                 if (!rx_byte[0] && !rx_byte[4]) blk <= rx_byte[BW:1];
               end else st <= SKIP;
          OFFS: begin ack <= 1'b1; off <= rx_byte[OW-1:0]; st <= WDAT; end
          WDAT: begin ack <= 1'b1; off <= {off[OW-1:PW], off[PW-1:0] + 1'b1}; end
          default: ;
        endcase
      end
      if (cfg_wr) begin
        sticky[cidx] <= rx_byte[7];
        prot[cidx]   <= rx_byte[0] | (sticky[cidx] & prot[cidx]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (arr_wr) begin
      mem[addr] <= rx_byte;
    end
  end

  a_r10_power_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (&sticky && !ack_valid && !tx_valid && st == IDLE));
  a_r2_read_keeps_block: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_go && st == SEL && rx_byte[0]) |=> $stable(blk));
  a_r3_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_go && st == WDAT) |=> off[OW-1:PW] == $past(off[OW-1:PW]));
  a_r4_block_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_go && &off) |=> off == '0);
  a_r6_data_acked: assert property (@(posedge clk) disable iff (!rst_n)
    data_byte |=> (ack_valid && ack));
  a_r8_locked_protect: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sticky) & $past(prot) & ~prot) == '0));
endmodule

// File: tb/tb_guarded_eeprom_ctrl.sv
`timescale 1ns/1ps
module tb_guarded_eeprom_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b1, hw_addr = 1'b1;
  logic bus_start = 0, bus_stop = 0, rx_valid = 0, tx_req = 0;
  logic [7:0] rx_byte = 0;
  logic ack_valid, ack, tx_valid;
  logic [7:0] tx_byte;

  guarded_eeprom_ctrl dut (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] mem_m [1024];
  logic [8:0] sticky_m, prot_m;
  logic [1:0] blk_m;
  logic [7:0] off_m;

  function automatic logic [7:0] cfg_byte(input logic [3:0] k);
    return (k <= 8) ? {sticky_m[k], 6'b0, prot_m[k]} : 8'h00;
  endfunction

  function automatic void mdl_cfg_write(input logic [3:0] k, input logic [7:0] v);
    if (prot_m[8] || k > 8) return;
    prot_m[k]   = v[0] | (sticky_m[k] & prot_m[k]);
    sticky_m[k] = v[7];
  endfunction

  function automatic void mdl_arr_write(input logic [7:0] v);
    logic [9:0] a = {blk_m, off_m};
    if (!prot_m[a[9:7]]) mem_m[a] = v;
    off_m = {off_m[7:4], off_m[3:0] + 4'd1};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic start_c(); @(negedge clk); bus_start = 1; @(negedge clk); bus_start = 0; endtask
  task automatic stop_c();  @(negedge clk); bus_stop = 1;  @(negedge clk); bus_stop = 0;  endtask

  task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
    chk(ack_valid === 1'b1 && ack === exp_ack, req, {ack_valid, ack}, {1'b1, exp_ack});
  endtask

  task automatic recv(input logic [7:0] exp, input string req);
    @(negedge clk); tx_req = 1;
    @(negedge clk); tx_req = 0;
    chk(tx_valid === 1'b1 && tx_byte === exp, req, tx_byte, exp);
  endtask

  task automatic wr_txn(input logic [1:0] b, input logic [7:0] o, input int n);
    start_c();
    send({4'b1010, hw_addr, b, 1'b0}, 1, "R1 select write"); blk_m = b;
    send(o, 1, "R3 offset"); off_m = o;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'($urandom);
      send(d, 1, "R6 data ack"); mdl_arr_write(d);
    end
    stop_c();
  endtask

  task automatic rd_txn(input bit with_addr, input logic [1:0] b, input logic [7:0] o, input int n);
    if (with_addr) begin
      start_c();
      send({4'b1010, hw_addr, b, 1'b0}, 1, "R2 dummy write"); blk_m = b;
      send(o, 1, "R3 offset"); off_m = o;
    end
    start_c();
    send({4'b1010, hw_addr, 2'($urandom), 1'b1}, 1, "R2 read select");
    for (int i = 0; i < n; i++) begin
      recv(mem_m[{blk_m, off_m}], with_addr ? "R4 read data" : "R5 read continue");
      off_m = off_m + 8'd1;
    end
    stop_c();
  endtask

  task automatic cfg_wr(input logic [3:0] k, input logic [7:0] v);
    start_c();
    send({4'b1011, hw_addr, 2'b00, 1'b0}, 1, "R1 cfg select");
    send({4'b0, k}, 1, "R7 cfg offset"); off_m = {4'b0, k};
    send(v, 1, "R9 cfg data ack"); mdl_cfg_write(k, v);
    off_m = {off_m[7:4], off_m[3:0] + 4'd1};
    stop_c();
  endtask

  task automatic cfg_chk(input logic [3:0] k, input string req);
    start_c();
    send({4'b1011, hw_addr, 2'b00, 1'b0}, 1, "R1 cfg select");
    send({4'b0, k}, 1, "R7 cfg offset"); off_m = {4'b0, k};
    start_c();
    send({4'b1011, hw_addr, 2'b00, 1'b1}, 1, "R1 cfg read select");
    recv(cfg_byte(k), req); off_m = off_m + 8'd1;
    stop_c();
  endtask

  initial begin
    #1ms;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem_m[i] = 8'h00;
    sticky_m = '1; prot_m = '0; blk_m = 0; off_m = 0;
    repeat (3) @(negedge clk);
    chk(ack_valid === 0 && tx_valid === 0, "R11 outputs idle", {ack_valid, tx_valid}, 0);
    rst_n = 1;
    rd_txn(0, 0, 0, 2);
    cfg_chk(4'd3, "R11 sticky set after reset");

    start_c();
    send({4'b1010, ~hw_addr, 2'b00, 1'b0}, 0, "R1 address mismatch");
    send(8'h55, 0, "R1 unaddressed byte");
    stop_c();

    wr_txn(2'd1, 8'hF8, 4);
    rd_txn(1, 2'd1, 8'hF8, 12);
    wr_txn(2'd2, 8'h35, 21);
    rd_txn(1, 2'd2, 8'h30, 16);
    rd_txn(1, 2'd3, 8'hFD, 6);
    wr_txn(2'd0, 8'h10, 2);
    rd_txn(0, 2'd3, 8'h00, 3);

    cfg_wr(4'd5, 8'h01);
    cfg_chk(4'd5, "R7 cfg protect readback");
    wr_txn(2'd2, 8'hA0, 3);
    rd_txn(1, 2'd2, 8'hA0, 3);
    cfg_wr(4'd5, 8'h00);
    cfg_chk(4'd5, "R8 clear allowed when sticky low");
    cfg_wr(4'd5, 8'h01);
    cfg_chk(4'd12, "R7 unused cfg byte reads zero");

    wr_txn(2'd3, 8'h40, 2);
    start_c();
    send({4'b1010, hw_addr, 2'd3, 1'b0}, 1, "R1 select write"); blk_m = 3;
    send(8'h44, 1, "R3 offset"); off_m = 8'h44;
    @(negedge clk); rx_valid = 1; rx_byte = 8'hC3; pwr_good = 0;
    @(negedge clk); rx_valid = 0;
    chk(ack_valid === 0, "R10 no ack while power low", ack_valid, 0);
    sticky_m = '1;
    @(negedge clk); pwr_good = 1;
    send(8'h99, 0, "R10 byte without start after power return");
    stop_c();
    rd_txn(1, 2'd3, 8'h44, 1);
    cfg_wr(4'd5, 8'h00);
    cfg_chk(4'd5, "R8 sticky keeps protect");
    wr_txn(2'd2, 8'hA8, 2);
    rd_txn(1, 2'd2, 8'hA8, 2);

    for (int it = 0; it < 40; it++) begin
      case ($urandom % 5)
        0, 1: wr_txn(2'($urandom), 8'($urandom), 1 + ($urandom % 20));
        2: rd_txn(1, 2'($urandom), 8'($urandom), 1 + ($urandom % 20));
        3: rd_txn(0, 2'($urandom), 8'h00, 1 + ($urandom % 10));
        default: begin
          logic [3:0] k = 4'($urandom % 8);
          cfg_wr(k, {1'($urandom), 6'($urandom), 1'($urandom)});
          cfg_chk(k, "R8 random cfg write");
        end
      endcase
    end

    cfg_wr(4'd8, 8'h01);
    cfg_wr(4'd2, 8'h01);
    cfg_chk(4'd2, "R9 cfg locked");
    cfg_chk(4'd8, "R7 cfg pair readback");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule